// File: doc/BRIEF.md
# Three-Level DMA Address Table Walker

This block turns a device DMA address into a physical page address. It walks three levels of 64-bit table entries held in memory: a region table, then a segment table, then a page table. A function supplies its table origin and an inclusive window, given as a lowest and a highest permitted DMA address. A translate request is checked against these first. If the checks pass, the block issues one memory read per level through a simple request/response port. When the walk ends it returns the page address, a permission and a page mask. If the walk fails, it also raises an error event that carries a code.

One fixed address, used for message-signalled interrupts, is never translated. It is returned unchanged with full permission. Only one walk is in flight at a time, and `busy` tells the requester when a new request will be taken. Every error also sets two sticky flags, which stay set until reset: a fault flag and a store-blocked flag.

Top module: `dma_xlate_walker`

## Requirements
- R1: A request whose address equals `MSI_ADDR` is answered with that same address, permission 2'b11, mask 64'hFFF and no error. No memory read is made, whatever the origin or the window.
- R2: A request with a zero table origin that is not the interrupt address raises error code 16'h0010, with permission 2'b00, page address 0, an all-ones mask and no memory read. This check wins over the window check.
- R3: An address below `win_lo` or above `win_hi` raises error code 16'h0020 with no memory read. Both bounds are inclusive, so an address equal to either bound is walked.
- R4: The region entry is read at (origin with bits [3:2] cleared) + addr[52:42]×8. The segment entry is read at the region entry's bits [63:14] + addr[41:31]×8. The page entry is read at the segment entry's bits [63:11] + addr[19:12]×8.
- R5: A region entry is used only if its bits [3:2] are 2'b11, and a segment entry only if its bits [3:2] are 2'b10. The entry's address field must also be non-zero. Otherwise the walk stops after that read.
- R6: A stopped walk, or a page entry equal to zero, raises error code 16'h0030 with bit 31 of `err_info` set. The other errors leave `err_info` at zero.
- R7: A non-zero page entry returns its bits [63:12] as the page address, with mask 64'hFFF and no error. The permission is 2'b00 if entry bit 10 is set and 2'b11 otherwise.
- R8: `fault_state` and `store_blocked` are 0 after reset, are set together with the first error, and stay set until reset. `err_addr` carries the request address.
- R9: `busy` is high from the cycle after a request is accepted until the cycle in which `rsp_valid` pulses for one cycle. Requests made while busy are ignored. At most one memory read is outstanding, and `mem_req_valid` is a single-cycle pulse.
- R10: After reset, `busy`, `rsp_valid`, `err_valid` and `mem_req_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translate request, accepted when not busy |
| req_addr | input | 64 | DMA address to translate |
| tbl_origin | input | 64 | Function table origin (bits [3:2] are flags) |
| win_lo | input | 64 | Lowest permitted DMA address |
| win_hi | input | 64 | Highest permitted DMA address |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read request pulse |
| mem_req_addr | output | 64 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Result pulse |
| rsp_addr | output | 64 | Translated page address |
| rsp_mask | output | 64 | Page offset mask |
| rsp_perm | output | 2 | 2'b11 read/write, 2'b00 none |
| err_valid | output | 1 | Error event request |
| err_code | output | 16 | Error code |
| err_info | output | 32 | Error info word, bit 31 is the Q bit |
| err_addr | output | 64 | Faulting DMA address |
| fault_state | output | 1 | Sticky error-state flag |
| store_blocked | output | 1 | Sticky store-blocked flag |

## Verification
The bench goes after the order of the early checks. It sends the interrupt address with a zero origin and with an excluded window, and sends a zero origin together with an out-of-window address. A design that checks in the wrong order would raise an error where a bypass is due, or report the wrong code. The window is probed exactly at each bound and one step beyond it. An off-by-one comparison would either reject an address it should walk or walk one it should reject. Walk failures are placed at each of the three levels, and the number of memory reads is counted for each. That catches a walker that skips the type check, ignores a zero page entry, or keeps reading after it should have stopped. An invalid page entry must give no permission without raising an error. A request made while busy must produce no second result.

// File: rtl/dwalk_pkg.sv
package dwalk_pkg;

  localparam int AW        = 64;
  localparam int PAGE_SH   = 12;
  localparam int RS_IDX_W  = 11;
  localparam int PG_IDX_W  = 8;
  localparam int SEG_LSB   = 31;
  localparam int RGN_LSB   = SEG_LSB + RS_IDX_W;
  localparam int ENT_SH    = 3;
  localparam int RGN_ALIGN = RS_IDX_W + ENT_SH;
  localparam int PT_ALIGN  = PG_IDX_W + ENT_SH;
  localparam int INV_BIT   = 10;
  localparam int Q_BIT     = 31;

  localparam logic [1:0]    TY_REGION = 2'b11;
  localparam logic [1:0]    TY_SEGMENT = 2'b10;
  localparam logic [AW-1:0] ORG_FLAGS = 64'h0000_0000_0000_000C;

  localparam logic [15:0] EC_NO_SPACE = 16'h0010;
  localparam logic [15:0] EC_RANGE    = 16'h0020;
  localparam logic [15:0] EC_WALK     = 16'h0030;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RW   = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_ISSUE, ST_WAIT
  } walk_state_e;

  typedef enum logic [1:0] {
    LV_REGION = 2'd0, LV_SEGMENT = 2'd1, LV_PAGE = 2'd2
  } walk_level_e;

  function automatic logic [AW-1:0] idx_offset(input logic [AW-1:0] a, input walk_level_e lv);
    logic [AW-1:0] ix;
    case (lv)
      LV_REGION:  ix = AW'(a[RGN_LSB +: RS_IDX_W]);
      LV_SEGMENT: ix = AW'(a[SEG_LSB +: RS_IDX_W]);
      default:    ix = AW'(a[PAGE_SH +: PG_IDX_W]);
    endcase
    return ix << ENT_SH;
  endfunction

  function automatic logic [AW-1:0] clear_low(input logic [AW-1:0] v, input int n);
    return (v >> n) << n;
  endfunction

  function automatic logic [1:0] entry_type(input logic [AW-1:0] e);
    return e[3:2];
  endfunction

endpackage

// File: rtl/walk_precheck.sv
module walk_precheck
  import dwalk_pkg::*;
#(
  parameter logic [AW-1:0] MSI_ADDR = 64'h0000_0000_FE00_0000
) (
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] origin,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          hit_bypass,
  output logic          no_space,
  output logic          out_of_win
);
  always_comb begin
    hit_bypass = (vaddr == MSI_ADDR);
    no_space   = !hit_bypass && (origin == '0);
    out_of_win = !hit_bypass && !no_space && ((vaddr < lo) || (vaddr > hi));
  end
endmodule

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
  import dwalk_pkg::*;
(
  input  walk_level_e   level,
  input  logic [AW-1:0] tbase,
  input  logic [AW-1:0] vaddr,
  output logic [AW-1:0] rd_addr
);
  always_comb rd_addr = tbase + idx_offset(vaddr, level);
endmodule

// File: rtl/walk_entry_eval.sv
module walk_entry_eval
  import dwalk_pkg::*;
(
  input  walk_level_e   level,
  input  logic [AW-1:0] entry,
  output logic          step_ok,
  output logic [AW-1:0] next_base,
  output logic [AW-1:0] page_addr,
  output logic          page_inv
);
  logic [AW-1:0] rgn_next, seg_next;

  always_comb begin
    rgn_next  = clear_low(entry, RGN_ALIGN);
    seg_next  = clear_low(entry, PT_ALIGN);
    page_addr = clear_low(entry, PAGE_SH);
    page_inv  = entry[INV_BIT];
    case (level)
      LV_REGION: begin
        step_ok   = (entry_type(entry) == TY_REGION) && (rgn_next != '0);
        next_base = rgn_next;
      end
      LV_SEGMENT: begin
        step_ok   = (entry_type(entry) == TY_SEGMENT) && (seg_next != '0);
        next_base = seg_next;
      end
      default: begin
        step_ok   = (entry != '0);
        next_base = '0;
      end
    endcase
  end
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
  import dwalk_pkg::*;
#(
  parameter logic [63:0] MSI_ADDR = 64'h0000_0000_FE00_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_addr,
  input  logic [63:0] tbl_origin,
  input  logic [63:0] win_lo,
  input  logic [63:0] win_hi,
  output logic        busy,
  output logic        mem_req_valid,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        rsp_valid,
  output logic [63:0] rsp_addr,
  output logic [63:0] rsp_mask,
  output logic [1:0]  rsp_perm,
  output logic        err_valid,
  output logic [15:0] err_code,
  output logic [31:0] err_info,
  output logic [63:0] err_addr,
  output logic        fault_state,
  output logic        store_blocked
);
  localparam logic [AW-1:0] PAGE_MASK = AW'((64'd1 << PAGE_SH) - 64'd1);

  walk_state_e   state;
  walk_level_e   level;
  logic [AW-1:0] r_addr, r_org, r_lo, r_hi, tbase;

  logic          ev_bypass, ev_no_space, ev_range;
  logic          pc_bypass, pc_no_space, pc_range;
  logic          step_ok, page_inv;
  logic [AW-1:0] next_base, page_addr;
  logic          ev_walk_fail, ev_walk_done;

  walk_precheck #(.MSI_ADDR(MSI_ADDR)) u_pre (
    .vaddr(r_addr), .origin(r_org), .lo(r_lo), .hi(r_hi),
    .hit_bypass(pc_bypass), .no_space(pc_no_space), .out_of_win(pc_range)
  );

  walk_addr_gen u_agen (
    .level(level), .tbase(tbase), .vaddr(r_addr), .rd_addr(mem_req_addr)
  );

  walk_entry_eval u_eval (
    .level(level), .entry(mem_rsp_data), .step_ok(step_ok),
    .next_base(next_base), .page_addr(page_addr), .page_inv(page_inv)
  );

  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_ISSUE);
  assign ev_bypass     = (state == ST_CHECK) && pc_bypass;
  assign ev_no_space   = (state == ST_CHECK) && pc_no_space;
  assign ev_range      = (state == ST_CHECK) && pc_range;
  assign ev_walk_fail  = (state == ST_WAIT) && mem_rsp_valid && !step_ok;
  assign ev_walk_done  = (state == ST_WAIT) && mem_rsp_valid && step_ok
                         && (level == LV_PAGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      level         <= LV_REGION;
      r_addr        <= '0;
      r_org         <= '0;
      r_lo          <= '0;
      r_hi          <= '0;
      tbase         <= '0;
      rsp_valid     <= 1'b0;
      rsp_addr      <= '0;
      rsp_mask      <= '1;
      rsp_perm      <= PERM_NONE;
      err_valid     <= 1'b0;
      err_code      <= '0;
      err_info      <= '0;
      err_addr      <= '0;
      fault_state   <= 1'b0;
      store_blocked <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      err_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            r_addr <= req_addr;
            r_org  <= tbl_origin;
            r_lo   <= win_lo;
            r_hi   <= win_hi;
            state  <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (ev_bypass) begin
            rsp_valid <= 1'b1;
            rsp_addr  <= r_addr;
            rsp_mask  <= PAGE_MASK;
            rsp_perm  <= PERM_RW;
            state     <= ST_IDLE;
          end else if (ev_no_space || ev_range) begin
            rsp_valid     <= 1'b1;
            rsp_addr      <= '0;
            rsp_mask      <= '1;
            rsp_perm      <= PERM_NONE;
            err_valid     <= 1'b1;
            err_code      <= ev_no_space ? EC_NO_SPACE : EC_RANGE;
            err_info      <= '0;
            err_addr      <= r_addr;
            fault_state   <= 1'b1;
            store_blocked <= 1'b1;
            state         <= ST_IDLE;
          end else begin
            level <= LV_REGION;
            tbase <= r_org & ~ORG_FLAGS;
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: begin
          if (ev_walk_fail) begin
            rsp_valid     <= 1'b1;
            rsp_addr      <= '0;
            rsp_mask      <= '1;
            rsp_perm      <= PERM_NONE;
            err_valid     <= 1'b1;
            err_code      <= EC_WALK;
            err_info      <= 32'(1) << Q_BIT;
            err_addr      <= r_addr;
            fault_state   <= 1'b1;
            store_blocked <= 1'b1;
            state         <= ST_IDLE;
          end else if (ev_walk_done) begin
            rsp_valid <= 1'b1;
            rsp_addr  <= page_addr;
            rsp_mask  <= PAGE_MASK;
            rsp_perm  <= page_inv ? PERM_NONE : PERM_RW;
            state     <= ST_IDLE;
          end else if (mem_rsp_valid) begin
            tbase <= next_base;
            level <= (level == LV_REGION) ? LV_SEGMENT : LV_PAGE;
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/walk_chk.sv
module walk_chk
  import dwalk_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req_valid,
  input logic        rsp_valid,
  input logic [63:0] rsp_mask,
  input logic [1:0]  rsp_perm,
  input logic        err_valid,
  input logic [15:0] err_code,
  input logic [31:0] err_info,
  input logic        fault_state,
  input logic        store_blocked,
  input logic        ev_bypass
);
  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bypass |=> rsp_valid && !err_valid && rsp_perm == PERM_RW);

  p_err_no_perm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> rsp_valid && rsp_perm == PERM_NONE && rsp_mask == '1);

  p_q_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_info[Q_BIT] == (err_code == EC_WALK)));

  p_ok_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !err_valid |-> rsp_mask == 64'hFFF);

  p_flags_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> fault_state && store_blocked);

  p_flags_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_state |=> fault_state && store_blocked);

  p_read_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  p_read_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  p_rsp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
endmodule

bind dma_xlate_walker walk_chk u_walk_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req_valid(mem_req_valid),
  .rsp_valid(rsp_valid), .rsp_mask(rsp_mask), .rsp_perm(rsp_perm),
  .err_valid(err_valid), .err_code(err_code), .err_info(err_info),
  .fault_state(fault_state), .store_blocked(store_blocked),
  .ev_bypass(ev_bypass)
);

// File: tb/tb_dma_xlate_walker.sv
module tb_dma_xlate_walker;
  localparam logic [63:0] MSI  = 64'h0000_0000_FE00_0000;
  localparam logic [63:0] ORG  = 64'h0000_0000_0001_000C;
  localparam logic [63:0] AOK  = 64'h0000_0401_0000_3123;
  localparam logic [63:0] AINV = 64'h0000_0401_0000_4000;
  localparam logic [63:0] AZP  = 64'h0000_0401_0000_5000;
  localparam logic [63:0] ASEG = 64'h0000_0401_8000_0000;
  localparam logic [63:0] ARGN = 64'h0000_0800_0000_0000;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 12;

  localparam logic [63:0] V_ADDR [NV] = '{AOK, AINV, AOK, AOK, MSI, MSI, AOK, AOK, AOK, ARGN, ASEG, AZP};
  localparam logic [63:0] V_ORG  [NV] = '{ORG, ORG, ORG, ORG, 64'd0, ORG, 64'd0, ORG, ORG, ORG, ORG, ORG};
  localparam logic [63:0] V_LO   [NV] = '{64'd0, 64'd0, 64'd0, AOK, 64'd0, MSI + 1, AOK + 1, 64'd0, AOK + 1, 64'd0, 64'd0, 64'd0};
  localparam logic [63:0] V_HI   [NV] = '{ONES, ONES, AOK, ONES, ONES, ONES, ONES, AOK - 1, ONES, ONES, ONES, ONES};
  localparam logic [63:0] V_PA   [NV] = '{64'hABCD000, 64'h55555000, 64'hABCD000, 64'hABCD000, MSI, MSI, 0, 0, 0, 0, 0, 0};
  localparam logic [1:0]  V_PERM [NV] = '{2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00};
  localparam logic [15:0] V_CODE [NV] = '{0, 0, 0, 0, 0, 0, 16'h10, 16'h20, 16'h20, 16'h30, 16'h30, 16'h30};
  localparam int          V_RD   [NV] = '{3, 3, 3, 3, 0, 0, 0, 0, 0, 1, 2, 3};

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [63:0] req_addr = 0, tbl_origin = 0, win_lo = 0, win_hi = 0;
  logic busy, mem_req_valid, mem_rsp_valid = 0;
  logic [63:0] mem_req_addr, mem_rsp_data = 0;
  logic rsp_valid, err_valid, fault_state, store_blocked;
  logic [63:0] rsp_addr, rsp_mask, err_addr;
  logic [1:0] rsp_perm;
  logic [15:0] err_code;
  logic [31:0] err_info;

  int tests = 0, fails = 0, reads = 0, rsp_cnt = 0, lat = 0;
  logic [63:0] pend_addr = 0;
  bit seen_err = 0;

  always #2.5 clk = ~clk;

  dma_xlate_walker #(.MSI_ADDR(MSI)) dut (.*);

  function automatic logic [63:0] mem_at(input logic [63:0] a);
    case (a)
      64'h10008: return 64'h2000C;
      64'h20010: return 64'h3008;
      64'h20018: return 64'h400C;
      64'h3018:  return 64'hABCD000;
      64'h3020:  return 64'h55555400;
      default:   return 64'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (lat != 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem_at(pend_addr);
      end
    end
    if (rst_n && mem_req_valid) begin
      lat <= 2;
      pend_addr <= mem_req_addr;
      reads <= reads + 1;
    end
    if (rst_n && rsp_valid) rsp_cnt <= rsp_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic walk(input logic [63:0] a, o, lo, hi);
    int t;
    reads = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; tbl_origin = o; win_lo = lo; win_hi = hi;
    @(negedge clk);
    req_valid = 0;
    check(busy == 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
    t = 0;
    while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
    check(t < 100, "R9 result returned", 64'(t), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !rsp_valid && !err_valid && !mem_req_valid, "R10 idle in reset",
          64'({busy, rsp_valid, err_valid, mem_req_valid}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    check(!fault_state && !store_blocked, "R8 flags clear after reset",
          64'({fault_state, store_blocked}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      walk(V_ADDR[i], V_ORG[i], V_LO[i], V_HI[i]);
      // R1 R2 R3 R7: result fields; R4 R5: read counts
      check(rsp_addr == V_PA[i], "R7 page address", rsp_addr, V_PA[i]);
      check(rsp_perm == V_PERM[i], "R7 permission", 64'(rsp_perm), 64'(V_PERM[i]));
      check(rsp_mask == (V_CODE[i] == 0 ? 64'hFFF : ONES), "R1 mask", rsp_mask,
            (V_CODE[i] == 0 ? 64'hFFF : ONES));
      check(err_valid == (V_CODE[i] != 0), "R2 error raised", 64'(err_valid), 64'(V_CODE[i] != 0));
      if (V_CODE[i] != 0) begin
        check(err_code == V_CODE[i], "R3 error code", 64'(err_code), 64'(V_CODE[i]));
        check(err_info[31] == (V_CODE[i] == 16'h30), "R6 Q bit", 64'(err_info),
              64'(V_CODE[i] == 16'h30));
        check(err_addr == V_ADDR[i], "R8 error address", err_addr, V_ADDR[i]);
        seen_err = 1;
      end
      check(reads == V_RD[i], "R5 read count", 64'(reads), 64'(V_RD[i]));
      @(negedge clk);
      check(fault_state == seen_err && store_blocked == seen_err, "R8 sticky flags",
            64'({fault_state, store_blocked}), 64'({seen_err, seen_err}));
    end

    // R4 read address sequence for a full walk
    reads = 0;
    @(negedge clk);
    req_valid = 1; req_addr = AOK; tbl_origin = ORG; win_lo = 0; win_hi = ONES;
    @(negedge clk);
    req_valid = 0;
    while (!mem_req_valid) @(negedge clk);
    check(mem_req_addr == 64'h10008, "R4 region read address", mem_req_addr, 64'h10008);
    @(negedge clk);
    while (!mem_req_valid) @(negedge clk);
    check(mem_req_addr == 64'h20010, "R4 segment read address", mem_req_addr, 64'h20010);
    @(negedge clk);
    while (!mem_req_valid) @(negedge clk);
    check(mem_req_addr == 64'h3018, "R4 page read address", mem_req_addr, 64'h3018);
    while (!rsp_valid) @(negedge clk);
    @(negedge clk);

    // R9 requests while busy are ignored
    rsp_cnt = 0;
    @(negedge clk);
    req_valid = 1; req_addr = AOK; tbl_origin = ORG; win_lo = 0; win_hi = ONES;
    @(negedge clk);
    req_addr = MSI;
    repeat (3) @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    check(rsp_addr == 64'hABCD000, "R9 first request kept", rsp_addr, 64'hABCD000);
    repeat (12) @(negedge clk);
    check(rsp_cnt == 1, "R9 single result", 64'(rsp_cnt), 64'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule